// File: doc/BRIEF.md
# Sleep Mode Control Unit

This block sits beside a small 8-bit processor core and governs its low-power states. Software programs an 8-bit control register through a single-register port, choosing a three-bit mode code and setting an enable flag. The core then pulses a strobe when it executes its sleep instruction. If the enable flag is set and the mode code is valid, the controller enters sleep. It halts the core and raises the clock-stop outputs that the chosen mode calls for.

While asleep, the controller watches two wake sources. An enabled interrupt starts a wake-up sequence. The clock-stop outputs drop at once, but the core stays halted for a fixed four-cycle hold plus a start-up delay set by a parameter. After that the controller releases the core and pulses a resume output, so the core continues after its sleep instruction. A reset request takes a separate path. It returns everything, the register included, to the reset state, and it flags that execution must restart from the reset vector.

Top module: `slpctl`

## Requirements
- R1: After reset, `reg_rdata` is 0x00, `halt` is 0, every gate output is 0, and `resume` and `rst_wake` are 0.
- R2: A write stores `reg_wdata[3:1]` as the mode code and `reg_wdata[0]` as the enable flag. `reg_rdata` shows them in the same bit positions, and bits 7:4 always read 0.
- R3: A strobe on `slp_stb` while the enable flag is 0 is ignored: `halt` and all gates stay 0.
- R4: A strobe while running, with the enable flag 1 and a valid mode, sets `halt` to 1 in the next cycle and raises that mode's gates in the same cycle.
- R5: With the gate vector written as {cpu, io, adc, tmr, osc}, where 1 means the clock is stopped, the modes decode as follows. 000 gives 10000, 001 gives 11000, 010 gives 11111, 011 gives 11101, 110 gives 11110, and 111 gives 11100.
- R6: Mode codes 100 and 101 are reserved. A strobe with either code, even with the enable flag 1, leaves `halt` and all gates at 0.
- R7: When `irq` is 1 during sleep, the gates go to 0 in the next cycle. `halt` then stays 1 for exactly 4 + STARTUP_CYC cycles counted from that cycle, and then falls.
- R8: `resume` is a one-cycle pulse in the first cycle after `halt` falls at the end of an interrupt wake-up.
- R9: When `wake_rst` is 1 during sleep, the next cycle shows `halt` 0, all gates 0, `reg_rdata` 0x00, no `resume`, and a one-cycle `rst_wake` pulse. `wake_rst` takes priority over `irq`.
- R10: Register writes while `halt` is 1 have no effect. The enable flag is still 1 after an interrupt wake-up.
- R11: `irq` while running has no effect on `halt` or the gates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| slp_stb | input | 1 | One-cycle pulse: sleep instruction executed |
| irq | input | 1 | Enabled interrupt pending |
| wake_rst | input | 1 | Synchronous reset request |
| gate_cpu | output | 1 | Stop CPU clock |
| gate_io | output | 1 | Stop I/O clock |
| gate_adc | output | 1 | Stop ADC clock |
| gate_tmr | output | 1 | Stop asynchronous timer clock |
| gate_osc | output | 1 | Stop main oscillator |
| halt | output | 1 | Core halted |
| resume | output | 1 | Pulse: continue after the sleep instruction |
| rst_wake | output | 1 | Pulse: woken by reset, restart at the reset vector |

## Verification
The assertions assume that `slp_stb` arrives only while the core is running, since a halted core cannot execute instructions. They also assume that `wake_rst` and `irq` are synchronous to `clk`. The halt-window check further assumes that, during a wake-up, no new sleep begins before `resume` is seen. The stimulus follows all of this: it drives every input at the falling edge, issues strobes only when `halt` is 0, and waits out each wake-up before issuing the next strobe.

// File: rtl/slpctl.sv
module slpctl #(
  parameter int STARTUP_CYC = 6,
  parameter int HOLD_CYC    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       slp_stb,
  input  logic       irq,
  input  logic       wake_rst,
  output logic       gate_cpu,
  output logic       gate_io,
  output logic       gate_adc,
  output logic       gate_tmr,
  output logic       gate_osc,
  output logic       halt,
  output logic       resume,
  output logic       rst_wake
);
  localparam int TOTAL = HOLD_CYC + STARTUP_CYC;
  localparam int CW    = $clog2(TOTAL + 1);

  typedef enum logic [1:0] {ST_RUN, ST_SLP, ST_WAKE} st_t;

  st_t           st;
  logic [2:0]    mode_q, mode_lat;
  logic          en_q;
  logic [CW-1:0] cnt;
  logic [4:0]    gv;

  wire mode_ok = mode_q[2:1] != 2'b10;
  wire go      = (st == ST_RUN) && slp_stb && en_q && mode_ok;

  function automatic logic [4:0] decode(input logic [2:0] m);
    case (m)
      3'b000:  decode = 5'b10000;
      3'b001:  decode = 5'b11000;
      3'b010:  decode = 5'b11111;
      3'b011:  decode = 5'b11101;
      3'b110:  decode = 5'b11110;
      3'b111:  decode = 5'b11100;
      default: decode = 5'b00000;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_RUN;
      mode_q   <= '0;
      en_q     <= 1'b0;
      mode_lat <= '0;
      cnt      <= '0;
      resume   <= 1'b0;
      rst_wake <= 1'b0;
    end else if (wake_rst) begin
      rst_wake <= (st == ST_SLP);
      st       <= ST_RUN;
      mode_q   <= '0;
      en_q     <= 1'b0;
      mode_lat <= '0;
      cnt      <= '0;
      resume   <= 1'b0;
    end else begin
      resume   <= 1'b0;
      rst_wake <= 1'b0;
      case (st)
        ST_RUN: begin
          if (reg_we) {mode_q, en_q} <= reg_wdata[3:0];
          if (go) begin
            st       <= ST_SLP;
            mode_lat <= mode_q;
          end
        end
        ST_SLP: if (irq) begin
          st  <= ST_WAKE;
          cnt <= '0;
        end
        ST_WAKE: begin
          if (cnt == CW'(TOTAL - 1)) begin
            st     <= ST_RUN;
            resume <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_RUN;
      endcase
    end
  end

  assign gv        = (st == ST_SLP) ? decode(mode_lat) : 5'b00000;
  assign {gate_cpu, gate_io, gate_adc, gate_tmr, gate_osc} = gv;
  assign halt      = st != ST_RUN;
  assign reg_rdata = {4'b0000, mode_q, en_q};
endmodule

// File: rtl/slpctl_chk.sv
module slpctl_chk #(
  parameter int STARTUP_CYC = 6,
  parameter int HOLD_CYC    = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [7:0] reg_rdata,
  input logic       slp_stb,
  input logic       irq,
  input logic       wake_rst,
  input logic       gate_cpu,
  input logic       gate_io,
  input logic       gate_adc,
  input logic       gate_tmr,
  input logic       gate_osc,
  input logic       halt,
  input logic       resume,
  input logic       rst_wake
);
  localparam int TOTAL = HOLD_CYC + STARTUP_CYC;
  wire any_g = gate_cpu | gate_io | gate_adc | gate_tmr | gate_osc;
  logic [15:0] hc;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hc <= '0;
    else if (halt && !any_g) hc <= hc + 16'd1;
    else hc <= '0;

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7:4] == 4'b0000);
  assert_gates_need_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    any_g |-> halt);
  assert_enable_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && slp_stb && !reg_rdata[0] && !wake_rst) |=> !halt);
  assert_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && slp_stb && reg_rdata[0] && reg_rdata[3:2] == 2'b10 && !wake_rst) |=> !halt);
  assert_irq_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && any_g && irq && !wake_rst) |=> (halt && !any_g));
  assert_halt_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> hc == 16'(TOTAL));
  assert_resume_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume);
  assert_rst_path_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_wake |-> (!halt && !resume && reg_rdata == 8'h00));
  assert_write_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !wake_rst) |=> $stable(reg_rdata));
  assert_irq_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && irq && !slp_stb && !wake_rst) |=> !halt);
endmodule

bind slpctl slpctl_chk #(.STARTUP_CYC(STARTUP_CYC), .HOLD_CYC(HOLD_CYC)) chk_i (.*);

// File: tb/slpctl_tb_top.sv
module slpctl_tb_top;
  localparam int STARTUP = 6;
  localparam int TOTAL   = 4 + STARTUP;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, slp_stb = 1'b0, irq = 1'b0, wake_rst = 1'b0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic gate_cpu, gate_io, gate_adc, gate_tmr, gate_osc, halt, resume, rst_wake;

  int checks = 0, fails = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #4 clk = ~clk;

  slpctl #(.STARTUP_CYC(STARTUP)) dut_i (.*);

  function automatic logic [15:0] mk(logic h, logic [4:0] g, logic rs, logic rw, logic [7:0] rd);
    return {h, g, rs, rw, rd};
  endfunction

  function automatic logic [4:0] gexp(logic [2:0] m);
    case (m)
      3'b000: return 5'b10000;
      3'b001: return 5'b11000;
      3'b010: return 5'b11111;
      3'b011: return 5'b11101;
      3'b110: return 5'b11110;
      3'b111: return 5'b11100;
      default: return 5'b00000;
    endcase
  endfunction

  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      logic [15:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {halt, gate_cpu, gate_io, gate_adc, gate_tmr, gate_osc, resume, rst_wake, reg_rdata};
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", t, a, e);
      end
    end
  end

  task automatic step(logic we, logic [7:0] wd, logic stb, logic iq, logic wr,
                      string tag, logic [15:0] e);
    reg_we = we; reg_wdata = wd; slp_stb = stb; irq = iq; wake_rst = wr;
    @(posedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    reg_we = 0; slp_stb = 0; irq = 0; wake_rst = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] modes[6] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b110, 3'b111};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, "R1 reset state", mk(0, 0, 0, 0, 8'h00));
    step(1, 8'hFF, 0, 0, 0, "R2 upper bits read zero", mk(0, 0, 0, 0, 8'h0F));
    step(1, 8'h04, 0, 0, 0, "R2 field placement", mk(0, 0, 0, 0, 8'h04));
    step(0, 0, 1, 0, 0, "R3 enable off ignored", mk(0, 0, 0, 0, 8'h04));
    step(0, 0, 0, 1, 0, "R11 irq while running", mk(0, 0, 0, 0, 8'h04));

    foreach (modes[i]) begin
      logic [7:0] rv;
      rv = {4'b0, modes[i], 1'b1};
      step(1, rv, 0, 0, 0, "R2 mode write", mk(0, 0, 0, 0, rv));
      step(0, 0, 1, 0, 0, "R4 R5 sleep entry gates", mk(1, gexp(modes[i]), 0, 0, rv));
      step(1, 8'h00, 0, 0, 0, "R10 write in sleep ignored", mk(1, gexp(modes[i]), 0, 0, rv));
      step(0, 0, 0, 1, 0, "R7 irq drops gates", mk(1, 0, 0, 0, rv));
      for (int k = 1; k < TOTAL; k++)
        step(k == 2, 8'h00, 0, 0, 0, "R7 R10 halt window", mk(1, 0, 0, 0, rv));
      step(0, 0, 0, 0, 0, "R8 resume pulse", mk(0, 0, 1, 0, rv));
      step(0, 0, 0, 0, 0, "R8 resume single cycle", mk(0, 0, 0, 0, rv));
    end

    step(1, 8'h09, 0, 0, 0, "R6 reserved write", mk(0, 0, 0, 0, 8'h09));
    step(0, 0, 1, 0, 0, "R6 reserved 100 no sleep", mk(0, 0, 0, 0, 8'h09));
    step(1, 8'h0B, 0, 0, 0, "R6 reserved write", mk(0, 0, 0, 0, 8'h0B));
    step(0, 0, 1, 0, 0, "R6 reserved 101 no sleep", mk(0, 0, 0, 0, 8'h0B));

    step(1, 8'h05, 0, 0, 0, "R9 setup", mk(0, 0, 0, 0, 8'h05));
    step(0, 0, 1, 0, 0, "R9 enter sleep", mk(1, 5'b11111, 0, 0, 8'h05));
    step(0, 0, 0, 1, 1, "R9 reset wake beats irq", mk(0, 0, 0, 1, 8'h00));
    step(0, 0, 0, 0, 0, "R9 rst_wake single cycle", mk(0, 0, 0, 0, 8'h00));
    step(0, 0, 1, 0, 0, "R9 register cleared stays awake", mk(0, 0, 0, 0, 8'h00));

    step(1, 8'h0D, 0, 0, 0, "R9 setup run", mk(0, 0, 0, 0, 8'h0D));
    step(0, 0, 0, 0, 1, "R9 reset while running", mk(0, 0, 0, 0, 8'h00));

    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule